// File: doc/BRIEF.md
# Execute and Writeback Stage with Branch Redirect

This block sits between the issue logic and the commit stage of an out-of-order core. A bundle of up to `ISSUE_W` issued instructions enters every cycle and passes through a delay line of `PIPE_DELAY` registers that models the issue-to-execute distance. The stage then walks the bundle slot by slot under a functional-unit budget of `EXEC_W`. Every instruction it reads is flagged as executed. Squashed instructions are passed over and draw nothing from the budget. Each instruction that completes leaves in the commit bundle at the same slot index it came in on. Execution is a single cycle.

In the cycle an instruction reaches commit, it also wakes its dependents, and its destination registers are set ready in a 64-entry scoreboard one cycle later. A completed branch that was mispredicted still goes to commit. In the same cycle the stage raises a redirect that carries the branch's sequence number, its computed target as the next fetch address, and a prediction-wrong flag. When more than one completed branch mispredicts in a cycle, the oldest one drives the redirect. Rename clears scoreboard bits through a single clear port when it allocates a register.

Top module: `exec_wb_unit`

## Requirements
- R1: A bundle applied at the inputs appears on the commit outputs exactly PIPE_DELAY+1 clock edges later. The delay line advances on every edge, so bundles presented on consecutive cycles come out on consecutive cycles.
- R2: Slots are read in order from slot 0. Reading stops at the first slot whose valid bit is low, or once EXEC_W unsquashed instructions have been read, or after the last slot.
- R3: Bit i of outExecuted is 1 for every slot i that was read, squashed or not. Given R2, the set bits always form a contiguous run starting at bit 0.
- R4: A squashed instruction that is read does not count toward the EXEC_W budget. It does not appear in the commit bundle, does not wake dependents and does not set scoreboard bits.
- R5: A completed instruction arriving in slot i sets outCommitValid[i]. Its sequence number appears on outCommitSeq bits [i*SEQ_W +: SEQ_W].
- R6: When a completed instruction has its mispredict bit set, sqValid and sqPredWrong are 1 in the same cycle that the branch is shown on the commit outputs, and the branch's own commit slot stays valid. In that cycle, sqSeq holds the branch's sequence number and sqNextPc holds its target.
- R7: When several completed instructions in one bundle are mispredicted, the redirect carries the one with the lowest sequence number.
- R8: A mispredict bit on a squashed slot, or on a slot that was not read, raises no redirect.
- R9: outWakeValid[i] is 1 in the same cycle as outCommitValid[i], with at most EXEC_W bits set.
- R10: One edge after a commit slot is shown, the scoreboard bit of each valid destination register of that slot reads 1 on sbReady. A slot carries up to two destinations, at inDstIdx bits [(i*2+j)*6 +: 6] with enable inDstValid[i*2+j]. A pulse on sbClrValid zeros bit sbClrIdx at the next edge. If a set and a clear hit the same bit on the same edge, the set wins.
- R11: After reset, all commit, executed, wake and redirect outputs are 0 and every scoreboard bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | ISSUE_W | Slot holds an issued instruction |
| inSquashed | input | ISSUE_W | Slot instruction has been squashed |
| inMispred | input | ISSUE_W | Slot instruction is a mispredicted branch |
| inSeq | input | ISSUE_W*SEQ_W | Per-slot sequence numbers |
| inTarget | input | ISSUE_W*PC_W | Per-slot computed branch targets |
| inDstValid | input | ISSUE_W*NDST | Per-slot destination enables |
| inDstIdx | input | ISSUE_W*NDST*PIDX_W | Per-slot physical destination indices |
| sbClrValid | input | 1 | Clear one scoreboard bit |
| sbClrIdx | input | PIDX_W | Scoreboard bit to clear |
| outExecuted | output | ISSUE_W | Slots read this cycle |
| outCommitValid | output | ISSUE_W | Commit bundle slot valid |
| outCommitSeq | output | ISSUE_W*SEQ_W | Commit bundle sequence numbers |
| outWakeValid | output | ISSUE_W | Dependent wakeup per slot |
| sqValid | output | 1 | Redirect request |
| sqSeq | output | SEQ_W | Sequence number of the redirecting branch |
| sqNextPc | output | PC_W | Corrected next fetch address |
| sqPredWrong | output | 1 | Prediction-incorrect flag |
| sbReady | output | PREGS | Scoreboard ready bits |

## Verification
The bench targets the budget boundary. A bundle of four live instructions must stop after two; a design that counted slots instead of completions would commit too many or too few when a squashed slot leads the bundle. The bench places a hole in the middle of a bundle, which catches a scan that skips over empty slots instead of stopping. It puts a mispredict on a squashed slot and on an unread slot, which catches redirects raised for instructions that never completed. It sends two mispredicts in one bundle with the younger one in the lower slot, which catches selection by slot position instead of by age. It times a scoreboard clear to land on the same edge as a writeback set, which catches a ready bit left cleared for a value that has already been produced.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  parameter int ISSUE_W = 4;
  parameter int EXEC_W  = 2;
  parameter int SEQ_W   = 8;
  parameter int PC_W    = 16;
  parameter int NDST    = 2;
  parameter int PREGS   = 64;
  localparam int PIDX_W = $clog2(PREGS);
  localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

  typedef struct packed {
    logic                            valid;
    logic                            squashed;
    logic                            mispred;
    logic [SEQ_W-1:0]                seq;
    logic [PC_W-1:0]                 target;
    logic [NDST-1:0]                 dstValid;
    logic [NDST-1:0][PIDX_W-1:0]     dstIdx;
  } slot_t;

  typedef slot_t [ISSUE_W-1:0] bundle_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [ISSUE_W-1:0] exeMask;
    logic [ISSUE_W-1:0] doneMask;
    logic               redirValid;
    logic [SLOT_W-1:0]  redirSlot;
  } ctrl_strobe_t;
endpackage

// File: rtl/ewb_issue_pipe.sv
module ewb_issue_pipe
  import ewb_pkg::*;
#(
  parameter int DELAY = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  bundle_t bundleIn,
  output bundle_t bundleOut
);
  generate
    if (DELAY == 0) begin : gNoDelay
      assign bundleOut = bundleIn;
    end else begin : gDelay
      bundle_t stage [DELAY];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int s = 0; s < DELAY; s++) stage[s] <= '0;
        end else begin
          stage[0] <= bundleIn;
          for (int s = 1; s < DELAY; s++) stage[s] <= stage[s-1];
        end
      end
      assign bundleOut = stage[DELAY-1];
    end
  endgenerate
endmodule

// File: rtl/ewb_ctrl.sv
module ewb_ctrl
  import ewb_pkg::*;
(
  input  logic [ISSUE_W-1:0]       slotValid,
  input  logic [ISSUE_W-1:0]       slotSquashed,
  input  logic [ISSUE_W-1:0]       slotMispred,
  input  logic [ISSUE_W*SEQ_W-1:0] slotSeq,
  output ctrl_strobe_t             strobe
);
  logic [ISSUE_W-1:0] exeMask, doneMask;

  // in-order scan under the functional-unit budget
  always_comb begin
    int  fuUsed;
    logic stop;
    fuUsed   = 0;
    stop     = 1'b0;
    exeMask  = '0;
    doneMask = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (!stop) begin
        if (!slotValid[i] || fuUsed >= EXEC_W) begin
          stop = 1'b1;
        end else begin
          exeMask[i] = 1'b1;
          if (!slotSquashed[i]) begin
            doneMask[i] = 1'b1;
            fuUsed      = fuUsed + 1;
          end
        end
      end
    end
  end

  // oldest completed mispredict wins
  always_comb begin
    logic [SEQ_W-1:0] bestSeq;
    bestSeq           = '0;
    strobe.redirValid = 1'b0;
    strobe.redirSlot  = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (doneMask[i] && slotMispred[i] &&
          (!strobe.redirValid || slotSeq[i*SEQ_W +: SEQ_W] < bestSeq)) begin
        strobe.redirValid = 1'b1;
        strobe.redirSlot  = SLOT_W'(i);
        bestSeq           = slotSeq[i*SEQ_W +: SEQ_W];
      end
    end
    strobe.exeMask  = exeMask;
    strobe.doneMask = doneMask;
  end
endmodule

// File: rtl/ewb_datapath.sv
module ewb_datapath
  import ewb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrl_strobe_t                    strobe,
  input  logic [ISSUE_W*SEQ_W-1:0]        slotSeq,
  input  logic [ISSUE_W*PC_W-1:0]         slotTarget,
  input  logic [ISSUE_W*NDST-1:0]         slotDstValid,
  input  logic [ISSUE_W*NDST*PIDX_W-1:0]  slotDstIdx,
  input  logic                            sbClrValid,
  input  logic [PIDX_W-1:0]               sbClrIdx,
  output logic [ISSUE_W-1:0]              outExecuted,
  output logic [ISSUE_W-1:0]              outCommitValid,
  output logic [ISSUE_W*SEQ_W-1:0]        outCommitSeq,
  output logic [ISSUE_W-1:0]              outWakeValid,
  output logic                            sqValid,
  output logic [SEQ_W-1:0]                sqSeq,
  output logic [PC_W-1:0]                 sqNextPc,
  output logic                            sqPredWrong,
  output logic [PREGS-1:0]                sbReady
);
  logic [ISSUE_W*NDST-1:0]        cmtDstValid;
  logic [ISSUE_W*NDST*PIDX_W-1:0] cmtDstIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outExecuted    <= '0;
      outCommitValid <= '0;
      outCommitSeq   <= '0;
      cmtDstValid    <= '0;
      cmtDstIdx      <= '0;
      sqValid        <= 1'b0;
      sqSeq          <= '0;
      sqNextPc       <= '0;
      sqPredWrong    <= 1'b0;
    end else begin
      outExecuted    <= strobe.exeMask;
      outCommitValid <= strobe.doneMask;
      outCommitSeq   <= slotSeq;
      cmtDstIdx      <= slotDstIdx;
      for (int i = 0; i < ISSUE_W; i++)
        for (int j = 0; j < NDST; j++)
          cmtDstValid[i*NDST+j] <= slotDstValid[i*NDST+j] & strobe.doneMask[i];
      sqValid     <= strobe.redirValid;
      sqPredWrong <= strobe.redirValid;
      sqSeq       <= strobe.redirValid ? slotSeq[strobe.redirSlot*SEQ_W +: SEQ_W] : '0;
      sqNextPc    <= strobe.redirValid ? slotTarget[strobe.redirSlot*PC_W +: PC_W] : '0;
    end
  end

  // wakeup for committed slots, capped at the execute width
  always_comb begin
    int cnt;
    cnt          = 0;
    outWakeValid = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (outCommitValid[i] && cnt < EXEC_W) begin
        outWakeValid[i] = 1'b1;
        cnt             = cnt + 1;
      end
    end
  end

  // scoreboard: clear first, writeback set overrides
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbReady <= '1;
    end else begin
      if (sbClrValid) sbReady[sbClrIdx] <= 1'b0;
      for (int k = 0; k < ISSUE_W*NDST; k++)
        if (cmtDstValid[k]) sbReady[cmtDstIdx[k*PIDX_W +: PIDX_W]] <= 1'b1;
    end
  end
endmodule

// File: rtl/exec_wb_unit.sv
module exec_wb_unit
  import ewb_pkg::*;
#(
  parameter int PIPE_DELAY = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ISSUE_W-1:0]              inValid,
  input  logic [ISSUE_W-1:0]              inSquashed,
  input  logic [ISSUE_W-1:0]              inMispred,
  input  logic [ISSUE_W*SEQ_W-1:0]        inSeq,
  input  logic [ISSUE_W*PC_W-1:0]         inTarget,
  input  logic [ISSUE_W*NDST-1:0]         inDstValid,
  input  logic [ISSUE_W*NDST*PIDX_W-1:0]  inDstIdx,
  input  logic                            sbClrValid,
  input  logic [PIDX_W-1:0]               sbClrIdx,
  output logic [ISSUE_W-1:0]              outExecuted,
  output logic [ISSUE_W-1:0]              outCommitValid,
  output logic [ISSUE_W*SEQ_W-1:0]        outCommitSeq,
  output logic [ISSUE_W-1:0]              outWakeValid,
  output logic                            sqValid,
  output logic [SEQ_W-1:0]                sqSeq,
  output logic [PC_W-1:0]                 sqNextPc,
  output logic                            sqPredWrong,
  output logic [PREGS-1:0]                sbReady
);
  bundle_t issueBundle, exeBundle;
  logic [ISSUE_W-1:0]              exValid, exSquashed, exMispred;
  logic [ISSUE_W*SEQ_W-1:0]        exSeq;
  logic [ISSUE_W*PC_W-1:0]         exTarget;
  logic [ISSUE_W*NDST-1:0]         exDstValid;
  logic [ISSUE_W*NDST*PIDX_W-1:0]  exDstIdx;
  ctrl_strobe_t                    strobe;

  always_comb begin
    for (int i = 0; i < ISSUE_W; i++) begin
      issueBundle[i].valid    = inValid[i];
      issueBundle[i].squashed = inSquashed[i];
      issueBundle[i].mispred  = inMispred[i];
      issueBundle[i].seq      = inSeq[i*SEQ_W +: SEQ_W];
      issueBundle[i].target   = inTarget[i*PC_W +: PC_W];
      for (int j = 0; j < NDST; j++) begin
        issueBundle[i].dstValid[j] = inDstValid[i*NDST+j];
        issueBundle[i].dstIdx[j]   = inDstIdx[(i*NDST+j)*PIDX_W +: PIDX_W];
      end
    end
  end

  ewb_issue_pipe #(.DELAY(PIPE_DELAY)) pipe_i (
    .clk(clk), .rstN(rstN), .bundleIn(issueBundle), .bundleOut(exeBundle)
  );

  always_comb begin
    for (int i = 0; i < ISSUE_W; i++) begin
      exValid[i]                 = exeBundle[i].valid;
      exSquashed[i]              = exeBundle[i].squashed;
      exMispred[i]               = exeBundle[i].mispred;
      exSeq[i*SEQ_W +: SEQ_W]    = exeBundle[i].seq;
      exTarget[i*PC_W +: PC_W]   = exeBundle[i].target;
      for (int j = 0; j < NDST; j++) begin
        exDstValid[i*NDST+j]                  = exeBundle[i].dstValid[j];
        exDstIdx[(i*NDST+j)*PIDX_W +: PIDX_W] = exeBundle[i].dstIdx[j];
      end
    end
  end

  ewb_ctrl ctrl_i (
    .slotValid(exValid), .slotSquashed(exSquashed), .slotMispred(exMispred),
    .slotSeq(exSeq), .strobe(strobe)
  );

  ewb_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .slotSeq(exSeq), .slotTarget(exTarget),
    .slotDstValid(exDstValid), .slotDstIdx(exDstIdx),
    .sbClrValid(sbClrValid), .sbClrIdx(sbClrIdx),
    .outExecuted(outExecuted), .outCommitValid(outCommitValid),
    .outCommitSeq(outCommitSeq), .outWakeValid(outWakeValid),
    .sqValid(sqValid), .sqSeq(sqSeq), .sqNextPc(sqNextPc),
    .sqPredWrong(sqPredWrong), .sbReady(sbReady)
  );
endmodule

// File: rtl/ewb_checker.sv
module ewb_checker
  import ewb_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [ISSUE_W-1:0]       outExecuted,
  input logic [ISSUE_W-1:0]       outCommitValid,
  input logic [ISSUE_W*SEQ_W-1:0] outCommitSeq,
  input logic [ISSUE_W-1:0]       outWakeValid,
  input logic                     sqValid,
  input logic [SEQ_W-1:0]         sqSeq,
  input logic                     sqPredWrong
);
  logic [ISSUE_W-1:0] exeInc;
  logic               sqInCommit;

  assign exeInc = outExecuted + 1'b1;

  always_comb begin
    sqInCommit = 1'b0;
    for (int i = 0; i < ISSUE_W; i++)
      if (outCommitValid[i] && outCommitSeq[i*SEQ_W +: SEQ_W] == sqSeq) sqInCommit = 1'b1;
  end

  AST_FU_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outCommitValid) <= EXEC_W);  // R2
  AST_EXEC_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (outExecuted & exeInc) == '0);  // R3
  AST_COMMIT_WAS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (outCommitValid & ~outExecuted) == '0);  // R4
  AST_REDIRECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> sqPredWrong);  // R6
  AST_BRANCH_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> sqInCommit);  // R6
  AST_WAKE_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (outWakeValid & ~outCommitValid) == '0);  // R9
endmodule

bind exec_wb_unit ewb_checker chk_i (
  .clk(clk), .rstN(rstN), .outExecuted(outExecuted), .outCommitValid(outCommitValid),
  .outCommitSeq(outCommitSeq), .outWakeValid(outWakeValid), .sqValid(sqValid),
  .sqSeq(sqSeq), .sqPredWrong(sqPredWrong)
);

// File: tb/exec_wb_unit_tb_top.sv
`timescale 1ns/1ps
module exec_wb_unit_tb_top;
  import ewb_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ISSUE_W-1:0]              inValid, inSquashed, inMispred;
  logic [ISSUE_W*SEQ_W-1:0]        inSeq;
  logic [ISSUE_W*PC_W-1:0]         inTarget;
  logic [ISSUE_W*NDST-1:0]         inDstValid;
  logic [ISSUE_W*NDST*PIDX_W-1:0]  inDstIdx;
  logic                            sbClrValid;
  logic [PIDX_W-1:0]               sbClrIdx;
  logic [ISSUE_W-1:0]              outExecuted, outCommitValid, outWakeValid;
  logic [ISSUE_W*SEQ_W-1:0]        outCommitSeq;
  logic                            sqValid, sqPredWrong;
  logic [SEQ_W-1:0]                sqSeq;
  logic [PC_W-1:0]                 sqNextPc;
  logic [PREGS-1:0]                sbReady;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exec_wb_unit #(.PIPE_DELAY(2)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    inValid = '0; inSquashed = '0; inMispred = '0; inSeq = '0; inTarget = '0;
    inDstValid = '0; inDstIdx = '0;
  endtask

  task automatic setSlot(input int i, input bit sq, input bit mp, input int seq, input int tgt);
    inValid[i] = 1'b1; inSquashed[i] = sq; inMispred[i] = mp;
    inSeq[i*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    inTarget[i*PC_W +: PC_W] = PC_W'(tgt);
  endtask

  task automatic setDst(input int i, input int j, input int idx);
    inDstValid[i*NDST+j] = 1'b1;
    inDstIdx[(i*NDST+j)*PIDX_W +: PIDX_W] = PIDX_W'(idx);
  endtask

  // inputs are set at a negedge; commit becomes visible three negedges later
  task automatic launch();
    @(negedge clk); clearIn();
    @(negedge clk);
    check("R1 not early", 64'(outCommitValid), 64'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 commit", 64'(outCommitValid), 0);
    check("R11 executed", 64'(outExecuted), 0);
    check("R11 wake", 64'(outWakeValid), 0);
    check("R11 redirect", 64'(sqValid), 0);
    check("R11 scoreboard", sbReady, {64{1'b1}});
  endtask

  task automatic t_basic();
    clearIn(); setSlot(0, 0, 0, 3, 0); setSlot(1, 0, 0, 4, 0);
    launch();
    check("R5 commit mask", 64'(outCommitValid), 64'b0011);
    check("R5 slot1 seq", 64'(outCommitSeq[1*SEQ_W +: SEQ_W]), 4);
    check("R3 executed", 64'(outExecuted), 64'b0011);
    check("R9 wake", 64'(outWakeValid), 64'b0011);
    check("R6 no redirect", 64'(sqValid), 0);
  endtask

  task automatic t_budget();
    clearIn(); for (int i = 0; i < 4; i++) setSlot(i, 0, 0, 10+i, 0);
    launch();
    check("R2 budget exe", 64'(outExecuted), 64'b0011);
    check("R2 budget commit", 64'(outCommitValid), 64'b0011);
  endtask

  task automatic t_squash();
    clearIn(); setSlot(0, 1, 0, 20, 0); setSlot(1, 0, 0, 21, 0);
    setSlot(2, 0, 0, 22, 0); setSlot(3, 0, 0, 23, 0);
    launch();
    check("R3 squashed read", 64'(outExecuted), 64'b0111);
    check("R4 squashed no budget", 64'(outCommitValid), 64'b0110);
    check("R5 slot2 seq", 64'(outCommitSeq[2*SEQ_W +: SEQ_W]), 22);
    check("R9 wake", 64'(outWakeValid), 64'b0110);
  endtask

  task automatic t_hole();
    clearIn(); setSlot(0, 0, 0, 30, 0); setSlot(2, 0, 0, 32, 0);
    launch();
    check("R2 stop at hole exe", 64'(outExecuted), 64'b0001);
    check("R2 stop at hole commit", 64'(outCommitValid), 64'b0001);
  endtask

  task automatic t_mispred();
    clearIn(); setSlot(0, 0, 0, 10, 0); setSlot(1, 0, 1, 11, 'h1234);
    launch();
    check("R6 sqValid", 64'(sqValid), 1);
    check("R6 sqSeq", 64'(sqSeq), 11);
    check("R6 sqNextPc", 64'(sqNextPc), 'h1234);
    check("R6 predWrong", 64'(sqPredWrong), 1);
    check("R6 branch commits", 64'(outCommitValid), 64'b0011);
    @(negedge clk);
    check("R6 one cycle", 64'(sqValid), 0);
  endtask

  task automatic t_oldest();
    clearIn(); setSlot(0, 1, 0, 35, 0); setSlot(1, 0, 1, 40, 'haaaa);
    setSlot(2, 0, 1, 37, 'hbbbb);
    launch();
    check("R7 valid", 64'(sqValid), 1);
    check("R7 oldest seq", 64'(sqSeq), 37);
    check("R7 oldest pc", 64'(sqNextPc), 'hbbbb);
  endtask

  task automatic t_ignored();
    clearIn(); setSlot(0, 1, 1, 50, 'h1111); setSlot(1, 0, 0, 51, 0);
    setSlot(2, 0, 0, 52, 0); setSlot(3, 0, 1, 53, 'h2222);
    launch();
    check("R8 no redirect", 64'(sqValid), 0);
    check("R8 commit", 64'(outCommitValid), 64'b0110);
  endtask

  task automatic t_stream();
    clearIn(); setSlot(0, 0, 0, 1, 0);
    @(negedge clk); clearIn(); setSlot(0, 0, 0, 2, 0);
    @(negedge clk); clearIn();
    @(negedge clk);
    check("R1 first seq", 64'(outCommitSeq[SEQ_W-1:0]), 1);
    check("R1 first valid", 64'(outCommitValid), 64'b0001);
    @(negedge clk);
    check("R1 second seq", 64'(outCommitSeq[SEQ_W-1:0]), 2);
    @(negedge clk);
    check("R1 drained", 64'(outCommitValid), 0);
  endtask

  task automatic t_scoreboard();
    int regs[4] = '{5, 9, 20, 30};
    foreach (regs[k]) begin
      sbClrValid = 1'b1; sbClrIdx = PIDX_W'(regs[k]); @(negedge clk);
    end
    sbClrValid = 1'b0;
    check("R10 cleared", 64'({sbReady[5], sbReady[9], sbReady[20], sbReady[30]}), 0);
    clearIn(); setSlot(0, 0, 0, 60, 0); setDst(0, 0, 5); setDst(0, 1, 9);
    setSlot(1, 1, 0, 61, 0); setDst(1, 0, 30);
    setSlot(2, 0, 0, 62, 0); setDst(2, 0, 20);
    launch();
    check("R10 not yet", 64'(sbReady[5]), 0);
    sbClrValid = 1'b1; sbClrIdx = 6'd20;
    @(negedge clk); sbClrValid = 1'b0;
    check("R10 both dsts", 64'({sbReady[5], sbReady[9]}), 64'b11);
    check("R10 set wins", 64'(sbReady[20]), 1);
    check("R4 squashed dst", 64'(sbReady[30]), 0);
  endtask

  initial begin
    clearIn(); sbClrValid = 1'b0; sbClrIdx = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_budget();
    t_squash();
    t_hole();
    t_mispred();
    t_oldest();
    t_ignored();
    t_stream();
    t_scoreboard();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule